// File: doc/BRIEF.md
# Dual-Clock Mailbox Register with Full Flag

This block carries one data word from a writer clock domain to a reader clock domain without passing it through a FIFO. The writer stores a word by asserting select and enable on a rising edge of its clock. An active-low full flag in the writer's domain then goes low. While the flag is low, the stored word cannot be overwritten. The reader takes the word by asserting its own select and enable. That read frees the mailbox, and the flag returns high in the writer's domain.

Each side signals its event by flipping a toggle bit. The other side samples that bit through a two-flop synchronizer. Each side compares its own toggle with the synchronized toggle of the other side to know whether a word is outstanding. The reader's data output is a multiplexer: it shows the mailbox word while the reader's select is high, and the word from the neighbouring FIFO otherwise. The two clocks may be unrelated or the same clock. A single asynchronous active-low reset empties the mailbox, and it represents the master or partial reset of the associated FIFO.

Top module: `mailbox_cdc`

## Requirements
- R1: While reset is low, and after it is released with no write since, `mbox_full_n` is 1.
- R2: A rising `wr_clk` edge with `wr_sel`=1, `wr_en`=1 and `mbox_full_n`=1 stores `wr_data` and drives `mbox_full_n` to 0 right after that edge.
- R3: While `mbox_full_n` is 0, a write attempt leaves the stored word and the flag unchanged.
- R4: `rd_data` equals the stored mailbox word when `rd_sel` is 1, and `fifo_q` when `rd_sel` is 0, with no clock in between.
- R5: A write becomes visible to the reader after two `rd_clk` edges. A rising `rd_clk` edge with `rd_sel`=1 and `rd_en`=1 while a word is visible takes the word, and `mbox_full_n` returns to 1 after the second following `wr_clk` edge.
- R6: A read attempt (`rd_sel`=1, `rd_en`=1) while no word is visible to the reader has no effect: a word written later still holds the flag low until it is itself read.
- R7: Asserting reset while the mailbox is full drives `mbox_full_n` to 1 and clears the stored word to zero.
- R8: A `wr_clk` edge with `wr_sel`=0 or `wr_en`=0 stores nothing and leaves `mbox_full_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Writer clock |
| wr_sel | input | 1 | Writer selects the mailbox |
| wr_en | input | 1 | Writer enable |
| wr_data | input | DW | Word to store |
| mbox_full_n | output | 1 | Active-low mailbox-full flag, in the writer's domain |
| rd_clk | input | 1 | Reader clock |
| rd_sel | input | 1 | Reader selects the mailbox (also steers the output mux) |
| rd_en | input | 1 | Reader enable |
| fifo_q | input | DW | FIFO output word, shown when the mailbox is not selected |
| rd_data | output | DW | Reader data output |

## Verification
If a toggle bit or a synchronizer stage holds a wrong value, the flag becomes permanently inverted or stuck. This shows on `mbox_full_n` at the first write or read after the fault, within two clock edges of the event. A stored word that is overwritten while the flag is low shows on `rd_data` as soon as the reader raises its select. A read accepted too early, or with no word present, puts the toggles out of step. The next write then either never sets the flag or sets it and then frees it without a read, which is visible within a few edges. The reference model predicts the flag and the output word on every clock, so each of these faults appears as a mismatch at the first cycle it affects.

// File: rtl/mailbox_cdc.sv
module mailbox_cdc #(
  parameter int DW   = 36,
  parameter int SYNC = 2
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          mbox_full_n,
  input  logic          rd_clk,
  input  logic          rd_sel,
  input  logic          rd_en,
  input  logic [DW-1:0] fifo_q,
  output logic [DW-1:0] rd_data
);

  logic            wr_tog, rd_tog;
  logic [SYNC-1:0] wr_tog_rs, rd_tog_ws;
  logic [DW-1:0]   mbox_q;
  logic            wr_take, rd_take, rd_pend;

  assign mbox_full_n = ~(wr_tog ^ rd_tog_ws[SYNC-1]);
  assign wr_take     = wr_sel & wr_en & mbox_full_n;
  assign rd_pend     = wr_tog_rs[SYNC-1] ^ rd_tog;
  assign rd_take     = rd_sel & rd_en & rd_pend;
  assign rd_data     = rd_sel ? mbox_q : fifo_q;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_tog    <= 1'b0;
      mbox_q    <= '0;
      rd_tog_ws <= '0;
    end else begin
      rd_tog_ws <= {rd_tog_ws[SYNC-2:0], rd_tog};
      if (wr_take) begin
        wr_tog <= ~wr_tog;
        mbox_q <= wr_data;
      end
    end
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_tog    <= 1'b0;
      wr_tog_rs <= '0;
    end else begin
      wr_tog_rs <= {wr_tog_rs[SYNC-2:0], wr_tog};
      if (rd_take) rd_tog <= ~rd_tog;
    end
  end

  p_take_sets_flag_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_sel && wr_en && mbox_full_n |=> !mbox_full_n);

  p_fall_needs_write_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $fell(mbox_full_n) |-> $past(wr_sel && wr_en));

  p_hold_word_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !mbox_full_n |=> $stable(mbox_q));

  p_read_clears_pend_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_sel && rd_en && rd_pend |=> !rd_pend);

  p_ack_needs_word_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_tog != $past(rd_tog)) |-> $past(rd_pend));

endmodule

// File: tb/mailbox_cdc_tb.sv
`timescale 1ns/1ps
module mailbox_cdc_tb;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_sel = 1'b0, wr_en = 1'b0, rd_sel = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0, fifo_q = '0;
  logic          mbox_full_n;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_bad = 0, cyc = 0;

  logic          m_full = 1'b0, m_pend = 1'b0;
  logic [DW-1:0] m_word = '0;
  int            wcd = 0, rcd = 0;

  always #2.5 clk = ~clk;

  mailbox_cdc #(.DW(DW), .SYNC(2)) u_dut (
    .rst_n(rst_n), .wr_clk(clk), .wr_sel(wr_sel), .wr_en(wr_en), .wr_data(wr_data),
    .mbox_full_n(mbox_full_n), .rd_clk(clk), .rd_sel(rd_sel), .rd_en(rd_en),
    .fifo_q(fifo_q), .rd_data(rd_data));

  always @(posedge clk) begin
    logic aw, ar;
    if (!rst_n) begin
      m_full = 1'b0; m_pend = 1'b0; m_word = '0; wcd = 0; rcd = 0;
    end else begin
      aw = wr_sel && wr_en && !m_full;
      ar = rd_sel && rd_en && m_pend;
      if (rcd > 0) begin rcd--; if (rcd == 0) m_full = 1'b0; end
      if (wcd > 0) begin wcd--; if (wcd == 0) m_pend = 1'b1; end
      if (aw) begin m_full = 1'b1; m_word = wr_data; wcd = 2; end
      if (ar) begin m_pend = 1'b0; rcd = 2; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected < 20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic compare(string tag);
    logic [DW-1:0] exp_d;
    exp_d = rd_sel ? m_word : fifo_q;
    n_chk++;
    if (mbox_full_n !== !m_full) begin
      n_bad++;
      $display("FAIL %s flag: actual %b expected %b", tag, mbox_full_n, !m_full);
    end
    n_chk++;
    if (rd_data !== exp_d) begin
      n_bad++;
      $display("FAIL %s data: actual %h expected %h", tag, rd_data, exp_d);
    end
  endtask

  task automatic step(string tag, logic ws, logic we, logic [DW-1:0] wd,
                      logic rs, logic re, logic [DW-1:0] fq);
    @(negedge clk);
    compare(tag);
    wr_sel = ws; wr_en = we; wr_data = wd; rd_sel = rs; rd_en = re; fifo_q = fq;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, '0, 0, 0, 36'(i * 7 + 3));
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step("R1", 0, 0, '0, 0, 0, 36'h111);
    @(negedge clk); rst_n = 1'b1;
    idle("R1", 3);
    step("R8", 1, 0, 36'hBAD0, 0, 0, 36'h222);
    step("R8", 0, 1, 36'hBAD1, 1, 0, 36'h333);
    step("R8", 0, 0, '0, 1, 0, 36'h444);
    step("R2", 1, 1, 36'hA5A5_1234, 0, 0, 36'h555);
    step("R2", 0, 0, '0, 1, 0, 36'h666);
    step("R3", 1, 1, 36'hDEAD_BEEF, 1, 0, 36'h777);
    step("R6", 0, 0, '0, 1, 1, 36'h888);
    step("R4", 0, 0, '0, 1, 0, 36'h999);
    step("R4", 0, 0, '0, 0, 0, 36'hAAA);
    step("R3", 1, 1, 36'hFFFF_FFFF, 1, 0, 36'hBBB);
    step("R5", 0, 0, '0, 1, 1, 36'hCCC);
    for (int i = 0; i < 6; i++) step("R5", 1, 1, 36'(36'h100 + i), 1, 0, 36'(i));
    idle("R5", 4);
    step("R5", 0, 0, '0, 1, 1, 36'h1);
    idle("R5", 4);
    step("R6", 0, 0, '0, 1, 1, 36'h2);
    step("R6", 0, 0, '0, 1, 1, 36'h3);
    step("R6", 1, 1, 36'h0C0C_0C0C, 0, 0, 36'h4);
    for (int i = 0; i < 8; i++) step("R6", 0, 0, '0, 1, 0, 36'h5);
    step("R5", 0, 0, '0, 1, 1, 36'h6);
    for (int i = 0; i < 20; i++)
      step("R5", (i % 3) == 0, 1'b1, 36'(36'h2000 + i), (i % 2) == 1, (i % 4) == 1, 36'(i));
    idle("R7", 2);
    step("R7", 1, 1, 36'h7777_7777, 1, 0, 36'h7);
    step("R7", 0, 0, '0, 1, 0, 36'h8);
    @(negedge clk); compare("R7"); rst_n = 1'b0;
    step("R7", 0, 0, '0, 1, 0, 36'h9);
    step("R7", 0, 0, '0, 1, 0, 36'hA);
    @(negedge clk); compare("R7"); rst_n = 1'b1;
    step("R1", 0, 0, '0, 1, 0, 36'hB);
    step("R2", 1, 1, 36'h1357_9BDF, 1, 0, 36'hC);
    idle("R4", 3);
    step("R5", 0, 0, '0, 1, 1, 36'hD);
    idle("R5", 4);
    @(negedge clk); compare("R5");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule